// File: doc/BRIEF.md
# Charger Safety Watchdog Timers

This block decides whether battery charging may run. It watches two things. The first is how long it has been since the host last wrote one of the two charge set-point registers, the voltage target or the current target. The second is how long the serial bus clock line has been held low without a break. If either watch runs past its limit, the block drops its charge-enable output. It also records which limit was crossed in a sticky two-bit cause flag.

Only a fresh write to one of the two set-point registers turns charging back on. After reset, charging stays off until the first such write. The register decode and the bus protocol engine sit outside this block; they hand it one write strobe per set-point register and the raw clock-line level. Both time limits are given in milliseconds and converted to clock cycles using a clock-frequency parameter, so a short simulation can use small counts.

Top module: `chg_safety_wdog`

## Requirements
- R1: After reset, `chg_en_o` is 0 and `cause_o` is 2'b00.
- R2: A cycle with `wr_vset_i` or `wr_iset_i` high sets `chg_en_o` to 1 and clears `cause_o` to 2'b00, both from the next clock edge on.
- R3: With no further write, `chg_en_o` falls exactly IDLE_CYC clock edges after the edge that took the last write, where IDLE_CYC = CLK_HZ*IDLE_MS/1000. `cause_o` bit 0 (inactivity) is then set.
- R4: Any write while charging is enabled restarts the inactivity count from zero.
- R5: The clock line passes through two synchronizing flops. A run of exactly SCL_CYC = CLK_HZ*SCL_MS/1000 or more consecutive low samples disables charging and sets `cause_o` bit 1 (clock stuck low). A shorter run has no effect, and any high sample restarts the count.
- R6: Once disabled, charging stays off and `cause_o` holds its value until a write arrives, however long the inputs stay idle.
- R7: If a write and a timer expiry fall on the same clock edge, the write wins: `chg_en_o` stays 1 and `cause_o` stays 2'b00.
- R8: Each timer expires once per run. A clock line that remains low after a re-enabling write does not disable charging again until it has gone high and then stayed low for SCL_CYC samples.
- R9: Cause bits are only recorded while charging is enabled. An expiry while already disabled leaves `cause_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_vset_i | input | 1 | One-cycle strobe: charge-voltage register written |
| wr_iset_i | input | 1 | One-cycle strobe: charge-current register written |
| scl_i | input | 1 | Raw serial clock line level, asynchronous |
| chg_en_o | output | 1 | Charging permitted |
| cause_o | output | 2 | Sticky timeout cause: bit 0 inactivity, bit 1 clock stuck low |

## Verification
The hardest case to reach from the ports is a write landing on the very edge where the inactivity timer expires. The bench counts edges from a reference write and places the second write exactly IDLE_CYC edges later. Each clock-line low run from 1 to SCL_CYC+4 cycles is swept, which covers both sides of the threshold. A stuck-low line held across a re-enabling write shows that an expiry fires only once per run.

// File: rtl/chg_wdog_pkg.sv
package chg_wdog_pkg;

    typedef struct packed {
        logic scl_stuck;
        logic idle;
    } cause_t;

    function automatic longint unsigned ms_to_cycles(input longint unsigned hz,
                                                     input longint unsigned ms);
        longint unsigned c;
        c = (hz * ms) / 64'd1000;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int cnt_width(input longint unsigned limit);
        return $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter longint unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic advance_i,
    output logic expire_o
);
    localparam int W = chg_wdog_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);
    localparam logic [W-1:0] TOP  = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart_i)           cnt <= '0;
        else if (advance_i && cnt != TOP) cnt <= cnt + 1'b1;
    end

    assign expire_o = advance_i && !restart_i && (cnt == LAST);

    // R8
    cnt_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);

    // R8
    expire_parks_chk: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> (cnt == TOP));
endmodule

// File: rtl/wdog_gate.sv
module wdog_gate
    import chg_wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   write_i,
    input  cause_t expire_i,
    output logic   en_o,
    output cause_t cause_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_o    <= 1'b0;
            cause_o <= '0;
        end else if (write_i) begin
            en_o    <= 1'b1;
            cause_o <= '0;
        end else if (en_o && (expire_i != '0)) begin
            en_o    <= 1'b0;
            cause_o <= expire_i;
        end
    end

    // R2
    write_enables_chk: assert property (@(posedge clk) disable iff (rst)
        write_i |=> (en_o && cause_o == '0));

    // R9
    cause_only_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cause_o != '0) |-> !en_o);

    // R6
    off_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_o && !write_i) |=> (!en_o && $stable(cause_o)));

    // R7
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (write_i && expire_i != '0) |=> en_o);
endmodule

// File: rtl/chg_safety_wdog.sv
module chg_safety_wdog
    import chg_wdog_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 100_000_000,
    parameter longint unsigned IDLE_MS = 175_000,
    parameter longint unsigned SCL_MS  = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_vset_i,
    input  logic       wr_iset_i,
    input  logic       scl_i,
    output logic       chg_en_o,
    output logic [1:0] cause_o
);
    localparam longint unsigned IDLE_CYC = ms_to_cycles(CLK_HZ, IDLE_MS);
    localparam longint unsigned SCL_CYC  = ms_to_cycles(CLK_HZ, SCL_MS);

    logic   write;
    logic   scl_s;
    cause_t expire;
    cause_t cause;

    assign write = wr_vset_i | wr_iset_i;

    wdog_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (scl_i),
        .q_o (scl_s)
    );

    wdog_timer #(.LIMIT(IDLE_CYC)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .restart_i (write),
        .advance_i (1'b1),
        .expire_o  (expire.idle)
    );

    wdog_timer #(.LIMIT(SCL_CYC)) u_scl (
        .clk       (clk),
        .rst       (rst),
        .restart_i (scl_s),
        .advance_i (!scl_s),
        .expire_o  (expire.scl_stuck)
    );

    wdog_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .write_i  (write),
        .expire_i (expire),
        .en_o     (chg_en_o),
        .cause_o  (cause)
    );

    assign cause_o = cause;

    // R5
    scl_high_no_stuck_chk: assert property (@(posedge clk) disable iff (rst)
        scl_s |-> !expire.scl_stuck);
endmodule

// File: tb/sim_chg_safety_wdog.sv
module sim_chg_safety_wdog;
    localparam longint unsigned CLK_HZ  = 400;
    localparam longint unsigned IDLE_MS = 1000;
    localparam longint unsigned SCL_MS  = 25;
    localparam int IDLE_N = 400;
    localparam int SCL_N  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wv = 1'b0, wc = 1'b0, scl = 1'b1;
    logic       en;
    logic [1:0] cause;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    chg_safety_wdog #(.CLK_HZ(CLK_HZ), .IDLE_MS(IDLE_MS), .SCL_MS(SCL_MS)) u0 (
        .clk(clk), .rst(rst), .wr_vset_i(wv), .wr_iset_i(wc), .scl_i(scl),
        .chg_en_o(en), .cause_o(cause)
    );

    task automatic tick(input logic a, input logic b, input logic s);
        wv = a; wc = b; scl = s;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic e_en, input logic [1:0] e_c);
        checks++;
        if (en !== e_en || cause !== e_c) begin
            errors++;
            $display("FAIL %s: en=%b cause=%b expected en=%b cause=%b",
                     req, en, cause, e_en, e_c);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(0, 0, 1); tick(0, 0, 1);
        chk("R1", 1'b0, 2'b00);
        rst = 1'b0;
        tick(0, 0, 1);
        chk("R1", 1'b0, 2'b00);

        // R3 inactivity sweep, once per strobe
        for (int s = 0; s < 2; s++) begin
            tick(s == 0, s == 1, 1);
            chk("R2", 1'b1, 2'b00);
            for (int k = 1; k <= IDLE_N + 20; k++) begin
                tick(0, 0, 1);
                if (k == IDLE_N - 1 || k == IDLE_N || k == IDLE_N + 20)
                    chk("R3", k < IDLE_N, (k < IDLE_N) ? 2'b00 : 2'b01);
            end
        end

        // R4 restart partway through
        tick(1, 0, 1);
        for (int k = 1; k <= 200; k++) tick(0, 0, 1);
        tick(0, 1, 1);
        for (int k = 1; k <= IDLE_N; k++) begin
            tick(0, 0, 1);
            if (k == IDLE_N - 1 || k == IDLE_N)
                chk("R4", k < IDLE_N, (k < IDLE_N) ? 2'b00 : 2'b01);
        end

        // R7 write on the expiry edge
        tick(1, 0, 1);
        for (int k = 1; k <= IDLE_N - 1; k++) tick(0, 0, 1);
        tick(0, 1, 1);
        chk("R7", 1'b1, 2'b00);
        for (int k = 1; k <= IDLE_N; k++) begin
            tick(0, 0, 1);
            if (k == IDLE_N - 1 || k == IDLE_N)
                chk("R7", k < IDLE_N, (k < IDLE_N) ? 2'b00 : 2'b01);
        end

        // R5 clock-low run sweep
        for (int n = 1; n <= SCL_N + 4; n++) begin
            tick(1, 0, 1);
            for (int k = 0; k < n; k++) tick(0, 0, 0);
            for (int k = 0; k < 4; k++) tick(0, 0, 1);
            chk("R5", n < SCL_N, (n < SCL_N) ? 2'b00 : 2'b10);
        end

        // R5 a high sample restarts the count
        tick(1, 0, 1);
        for (int k = 0; k < SCL_N - 1; k++) tick(0, 0, 0);
        tick(0, 0, 1);
        for (int k = 0; k < SCL_N - 1; k++) tick(0, 0, 0);
        for (int k = 0; k < 4; k++) tick(0, 0, 1);
        chk("R5", 1'b1, 2'b00);

        // R6 / R9: disabled by clock, then idle expiry passes while off
        for (int k = 0; k < SCL_N + 4; k++) tick(0, 0, 0);
        chk("R5", 1'b0, 2'b10);
        for (int k = 0; k < IDLE_N + 20; k++) tick(0, 0, 1);
        chk("R6", 1'b0, 2'b10);
        chk("R9", 1'b0, 2'b10);

        // R8 stuck-low line held across a re-enabling write
        for (int k = 0; k < SCL_N + 4; k++) tick(0, 0, 0);
        tick(0, 1, 0);
        for (int k = 0; k < 3 * SCL_N; k++) tick(0, 0, 0);
        chk("R8", 1'b1, 2'b00);
        tick(0, 0, 1); tick(0, 0, 1);
        for (int k = 0; k < SCL_N + 4; k++) tick(0, 0, 0);
        chk("R8", 1'b0, 2'b10);

        // R1 reset mid-run
        tick(1, 0, 1);
        rst = 1'b1;
        tick(0, 0, 1);
        chk("R1", 1'b0, 2'b00);
        rst = 1'b0;
        tick(0, 0, 1);
        chk("R1", 1'b0, 2'b00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule